// File: doc/BRIEF.md
# Four-mode bidirectional shift register

This block is a small register of `WIDTH` bits (four by default) that is updated on every rising clock edge. A two-bit mode code picks one of four synchronous operations: wipe the register to zero, move every bit one place toward the top position, move every bit one place toward bit 0, or copy a parallel word in. Each shift direction has its own serial input. The bit that enters at the vacated end comes from the input for that direction.

No mode code keeps the contents unchanged. The all-zero mode code wipes the register, so a design that wants to keep a value must stop its clock. The parallel outputs sit behind an active-high output enable. When the enable is low, the pins are released to high impedance. The register underneath keeps taking clock edges the whole time. The block has no reset pin. After power-up, a single edge in the clear mode gives a known all-zero state.

Typical uses are serial-to-parallel and parallel-to-serial conversion, and a bus-side holding register that several such registers share through their output enables.

Top module: `ushreg`

## Requirements
- R1: With mode code 2'b00, the register becomes all zeros at the next rising edge, whatever the parallel and serial inputs carry.
- R2: With mode code 2'b11, the register takes `par_in` at the next rising edge, bit i into bit i. Both serial inputs have no effect.
- R3: With mode code 2'b01 (upward shift), bit 0 takes `ser_up_in` and each bit i>0 takes the old bit i-1.
- R4: With mode code 2'b10 (downward shift), the top bit takes `ser_dn_in` and each bit i<WIDTH-1 takes the old bit i+1.
- R5: During a shift, the serial input for the other direction and `par_in` have no effect on the result.
- R6: While `out_en` is high, `q_out` equals the register contents.
- R7: While `out_en` is low, every bit of `q_out` is released to high impedance. A two-state simulator resolves the undriven pins to 0.
- R8: The register keeps updating on clock edges while `out_en` is low. Raising `out_en` again shows the contents that the modes applied during that time produced.
- R9: The contents change only at a rising clock edge. Changing the mode or data inputs between edges leaves `q_out` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all updates happen on its rising edge |
| mode_sel | input | 2 | Operation code: 00 clear, 01 upward shift, 10 downward shift, 11 parallel copy |
| par_in | input | WIDTH | Parallel word for the copy mode |
| ser_up_in | input | 1 | Serial bit that enters bit 0 during an upward shift |
| ser_dn_in | input | 1 | Serial bit that enters the top bit during a downward shift |
| out_en | input | 1 | High drives `q_out`; low releases it to high impedance |
| q_out | output | WIDTH | Register contents, or high impedance |

## Verification
The bench goes after the cases where one input is swapped for another:
- a clear that lets data leak through would leave ones behind;
- a shift that takes its entry bit from the wrong serial input, or from `par_in`, leaves a wrong end bit;
- a copy that mixes in a serial bit corrupts bit 0 or the top bit.

It runs shifts with the enable low and then raises the enable. This catches a design that gates its register with the enable, because such a design shows a stale value. It changes inputs between edges and rechecks the outputs to expose any path from input to output that bypasses the flops. A long random run against a bench model covers every mode following every other.

// File: rtl/ushreg_pkg.sv
package ushreg_pkg;

    typedef enum logic [1:0] {
        M_CLEAR = 2'b00,
        M_UP    = 2'b01,
        M_DOWN  = 2'b10,
        M_LOAD  = 2'b11
    } mode_e;

    function automatic mode_e decode_mode(input logic [1:0] code);
        return mode_e'(code);
    endfunction

endpackage

// File: rtl/ushreg_next.sv
module ushreg_next
    import ushreg_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  mode_e              mode,
    input  logic [WIDTH-1:0]   cur,
    input  logic [WIDTH-1:0]   par_in,
    input  logic               ser_up_in,
    input  logic               ser_dn_in,
    output logic [WIDTH-1:0]   nxt
);
    localparam int TOP = WIDTH - 1;

    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        logic from_below;
        logic from_above;
        if (i == 0) begin : g_lo
            assign from_below = ser_up_in;
        end else begin : g_lo
            assign from_below = cur[i-1];
        end
        if (i == TOP) begin : g_hi
            assign from_above = ser_dn_in;
        end else begin : g_hi
            assign from_above = cur[i+1];
        end

        always_comb begin
            unique case (mode)
                M_CLEAR: nxt[i] = 1'b0;
                M_UP:    nxt[i] = from_below;
                M_DOWN:  nxt[i] = from_above;
                M_LOAD:  nxt[i] = par_in[i];
                default: nxt[i] = 1'b0;
            endcase
        end
    end
endmodule

// File: rtl/ushreg_bank.sv
module ushreg_bank
    import ushreg_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  mode_e            mode,
    input  logic [WIDTH-1:0] par_in,
    input  logic             ser_up_in,
    input  logic             ser_dn_in,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    always_ff @(posedge clk) begin
        q <= d;
    end

    // Contents are known once a clear or a copy has happened.
    logic known_q;
    always_ff @(posedge clk) begin
        known_q <= known_q | (mode == M_CLEAR) | (mode == M_LOAD);
    end

    // R1
    clear_zero_chk: assert property (@(posedge clk)
        (mode == M_CLEAR) |=> (q == '0));

    // R2
    load_copy_chk: assert property (@(posedge clk)
        (mode == M_LOAD) |=> (q == $past(par_in)));

    // R3
    shift_up_chk: assert property (@(posedge clk) disable iff (!known_q)
        (mode == M_UP) |=> (q == {$past(q[WIDTH-2:0]), $past(ser_up_in)}));

    // R4
    shift_down_chk: assert property (@(posedge clk) disable iff (!known_q)
        (mode == M_DOWN) |=> (q == {$past(ser_dn_in), $past(q[WIDTH-1:1])}));
endmodule

// File: rtl/ushreg_drive.sv
module ushreg_drive #(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             out_en,
    input  logic [WIDTH-1:0] state,
    output logic [WIDTH-1:0] pins
);
    assign pins = out_en ? state : {WIDTH{1'bz}};

    // R6
    enabled_view_chk: assert property (@(posedge clk)
        out_en |-> (pins == state));
endmodule

// File: rtl/ushreg.sv
module ushreg
    import ushreg_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic [1:0]       mode_sel,
    input  logic [WIDTH-1:0] par_in,
    input  logic             ser_up_in,
    input  logic             ser_dn_in,
    input  logic             out_en,
    output logic [WIDTH-1:0] q_out
);
    mode_e            mode;
    logic [WIDTH-1:0] cur;
    logic [WIDTH-1:0] nxt;

    assign mode = decode_mode(mode_sel);

    ushreg_next #(.WIDTH(WIDTH)) u_next (
        .mode      (mode),
        .cur       (cur),
        .par_in    (par_in),
        .ser_up_in (ser_up_in),
        .ser_dn_in (ser_dn_in),
        .nxt       (nxt)
    );

    ushreg_bank #(.WIDTH(WIDTH)) u_bank (
        .clk       (clk),
        .mode      (mode),
        .par_in    (par_in),
        .ser_up_in (ser_up_in),
        .ser_dn_in (ser_dn_in),
        .d         (nxt),
        .q         (cur)
    );

    ushreg_drive #(.WIDTH(WIDTH)) u_drive (
        .clk    (clk),
        .out_en (out_en),
        .state  (cur),
        .pins   (q_out)
    );
endmodule

// File: tb/ushreg_test.sv
module ushreg_test;
    localparam int WIDTH  = 4;
    localparam int PERIOD = 10;

    logic             clk = 1'b0;
    logic [1:0]       mode_sel = 2'b00;
    logic [WIDTH-1:0] par_in = '0;
    logic             ser_up_in = 1'b0;
    logic             ser_dn_in = 1'b0;
    logic             out_en = 1'b1;
    logic [WIDTH-1:0] q_out;

    logic [WIDTH-1:0] model;
    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #(PERIOD/2) clk = ~clk;

    ushreg #(.WIDTH(WIDTH)) uut (
        .clk(clk), .mode_sel(mode_sel), .par_in(par_in),
        .ser_up_in(ser_up_in), .ser_dn_in(ser_dn_in),
        .out_en(out_en), .q_out(q_out)
    );

    function automatic logic [WIDTH-1:0] ref_next(
        input logic [WIDTH-1:0] cur, input logic [1:0] m,
        input logic [WIDTH-1:0] p, input logic su, input logic sd);
        case (m)
            2'b00:   return '0;
            2'b01:   return {cur[WIDTH-2:0], su};
            2'b10:   return {sd, cur[WIDTH-1:1]};
            default: return p;
        endcase
    endfunction

    task automatic check(input string req, input logic [WIDTH-1:0] exp);
        checks++;
        if (q_out !== exp) begin
            fails++;
            $display("FAIL %s: q_out=%b expected %b", req, q_out, exp);
        end
    endtask

    // High impedance reads as z in four-state tools and 0 in two-state ones.
    task automatic check_released(input string req);
        checks++;
        if (!(q_out === {WIDTH{1'bz}} || q_out === '0)) begin
            fails++;
            $display("FAIL %s: q_out=%b expected %b", req, q_out, {WIDTH{1'bz}});
        end
    endtask

    // Drive at the falling edge, let one rising edge pass, then sample.
    task automatic step(input logic [1:0] m, input logic [WIDTH-1:0] p,
                        input logic su, input logic sd, input logic oe);
        @(negedge clk);
        mode_sel = m; par_in = p; ser_up_in = su; ser_dn_in = sd; out_en = oe;
        @(posedge clk);
        model = ref_next(model, m, p, su, sd);
        #1;
    endtask

    function automatic string tag_of(input logic [1:0] m);
        case (m)
            2'b00:   return "R1";
            2'b01:   return "R3";
            2'b10:   return "R4";
            default: return "R2";
        endcase
    endfunction

    initial begin
        model = '0;
        void'($urandom(32'd4242));
        // R1 first clear from unknown power-up state, with data all ones
        step(2'b00, 4'b1111, 1'b1, 1'b1, 1'b1); check("R1", 4'b0000);
        // R2 load ignores serial inputs
        step(2'b11, 4'b1010, 1'b1, 1'b1, 1'b1); check("R2", 4'b1010);
        step(2'b11, 4'b0101, 1'b0, 1'b0, 1'b1); check("R2", 4'b0101);
        // R3 upward shift enters ser_up_in at bit 0
        step(2'b01, 4'b0000, 1'b1, 1'b0, 1'b1); check("R3", 4'b1011);
        // R5 other serial input and par_in ignored on upward shift
        step(2'b01, 4'b1111, 1'b0, 1'b1, 1'b1); check("R5", 4'b0110);
        // R4 downward shift enters ser_dn_in at the top
        step(2'b10, 4'b0000, 1'b0, 1'b1, 1'b1); check("R4", 4'b1011);
        // R5 on downward shift
        step(2'b10, 4'b1111, 1'b1, 1'b0, 1'b1); check("R5", 4'b0101);
        // R1 clear ignores all data
        step(2'b11, 4'b1111, 1'b0, 1'b0, 1'b1); check("R2", 4'b1111);
        step(2'b00, 4'b1111, 1'b1, 1'b1, 1'b1); check("R1", 4'b0000);
        // R9 inputs changed between edges leave outputs alone
        step(2'b11, 4'b1001, 1'b0, 1'b0, 1'b1); check("R6", 4'b1001);
        mode_sel = 2'b00; par_in = 4'b0110; ser_up_in = 1'b1; ser_dn_in = 1'b1;
        #2; check("R9", 4'b1001);
        mode_sel = 2'b11; #1; check("R9", 4'b1001);
        // R7 released pins, R8 updates continue while released
        step(2'b01, 4'b0000, 1'b1, 1'b0, 1'b0); check_released("R7");
        step(2'b01, 4'b0000, 1'b1, 1'b0, 1'b0); check_released("R7");
        @(negedge clk); out_en = 1'b1; mode_sel = 2'b11; par_in = model;
        #1; check("R8", 4'b0111);
        // Random run against the model
        for (int n = 0; n < 400; n++) begin
            logic [1:0] m;
            logic oe;
            m  = 2'($urandom_range(0, 3));
            oe = ($urandom_range(0, 3) != 0);
            step(m, WIDTH'($urandom), 1'($urandom), 1'($urandom), oe);
            if (oe) check(tag_of(m), model);
            else    check_released("R7");
        end
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        #(PERIOD * 200000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule